// File: doc/BRIEF.md
# Carriage-Return Trained Baud Clock Generator

This block learns the bit rate of an asynchronous serial link by timing a carriage-return character (0x0D) on the receive line, and produces a clock-enable pulse at CLOCK_FACTOR times that rate for a UART transmitter and receiver sharing the same system clock. The host presses enter once, and the generator lines up with whatever baud rate the terminal uses, whatever the system clock frequency.

With least-significant-bit-first framing, 0x0D on the line reads as start(0), 1, 0, 1, 1, 0, 0, 0, 0, stop(1). That gives six edges, at 0, 1, 2, 3, 5 and 9 bit times after the start-bit falling edge. The block times the five gaps between them. It checks each gap against the first one, counts system clocks over the 9-bit span, and divides that span by 9 x CLOCK_FACTOR with a free-running prescaler, so no divider is needed. A pattern that does not fit is dropped and the previous rate stays in force. After an attempt ends, the next falling edge is only taken as a start bit once the line has been high for at least two measured bit times (no minimum after reset or after a saturated count). Each later carriage return retrains the rate without a reset.

Top module: `cr_autobaud`

## Requirements
- R1: After a valid 0x0D whose start-bit falling edge and stop-bit rising edge are T system clocks apart, `locked` is 1 and `baud_tick` pulses once every floor(T / (9 x CLOCK_FACTOR)) clocks (fraction truncated).
- R2: From reset until the first accepted measurement, `locked` is 0 and `baud_tick` pulses once every 2^LOG2_MAX_COUNT - 1 clocks.
- R3: A later 0x0D at a different bit rate replaces the divisor without a reset, and `locked` never falls once it has risen.
- R4: A character is accepted only if, with u the first gap (start bit), the four following gaps lie within u/2 (u halved, truncated) of u, u, 2u and 4u respectively. Any other character (for example 0x55 or 0x0B) leaves the divisor and `locked` unchanged.
- R5: A measurement that matches the pattern but gives a divisor of 0 (span below 9 x CLOCK_FACTOR clocks) is discarded, and the previous divisor is kept.
- R6: If any gap reaches 2^LOG2_MAX_COUNT - 1 clocks without an edge (for example a line break), the measurement is aborted, the divisor and `locked` are kept, and the next 0x0D trains normally.
- R7: `baud_tick` is one clock wide when the divisor is 2 or more, and held high every clock when the divisor is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high, asynchronous to clk |
| baud_tick | output | 1 | Clock-enable pulse at CLOCK_FACTOR times the learned bit rate |
| locked | output | 1 | High once a carriage return has been accepted |

## Verification
The bench goes after the divisor arithmetic at its edges. It uses a bit period that does not divide evenly, which a design that rounds instead of truncating would get one count off. It sends a carriage return so fast that the quotient is zero, which a design without the zero guard would accept, freezing or flooding the tick. It also checks the divisor-one case, where a counter that compares against the wrong terminal value produces no tick at all. It sends look-alike characters, one with a doubled early gap and one with uniform gaps, which a design with loose or missing gap checks would accept as a new rate. It holds the line low long enough to saturate the gap counter, which a design that does not abort would report as a huge divisor. A retrain at a second rate and a stepped-down third rate catch a divisor that only loads once.

// File: rtl/cr_autobaud_pkg.sv
package cr_autobaud_pkg;

    // Measurement engine states
    typedef enum logic [0:0] {
        MS_HUNT = 1'b0,   // waiting for an armed start edge
        MS_MEAS = 1'b1    // timing the gaps of a candidate character
    } meas_state_e;

    // Carriage return yields five gaps after the start edge; index of the last
    localparam logic [2:0] LAST_GAP_IDX = 3'd4;

    // Bit times spanned from start-bit fall to stop-bit rise for 0x0D
    localparam int CR_SPAN_BITS = 9;

endpackage

// File: rtl/ab_line_sync.sv
module ab_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line,
    output logic fall,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], rxd};
        r_d.prev  = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;   // idle line is high
        end else begin
            r_q <= r_d;
        end
    end

    assign line = r_q.chain[STAGES-1];
    assign fall = r_q.prev & ~line;
    assign rise = ~r_q.prev & line;

endmodule

// File: rtl/ab_measure.sv
module ab_measure
    import cr_autobaud_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int CLOCK_FACTOR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             fall,
    input  logic             rise,
    output logic             upd_valid,
    output logic [CNT_W-1:0] upd_div
);

    localparam int MODULUS = CR_SPAN_BITS * CLOCK_FACTOR;
    localparam int PRE_W   = $clog2(MODULUS);
    localparam int GUARD_W = CNT_W + 1;
    localparam int EXT_W   = CNT_W + 3;
    localparam logic [PRE_W-1:0]   PRE_LAST = PRE_W'(MODULUS - 1);
    localparam logic [CNT_W-1:0]   SEG_MAX  = '1;
    localparam logic [GUARD_W-1:0] IDLE_MAX = '1;

    typedef struct packed {
        meas_state_e        st;
        logic [2:0]         gap_n;   // gaps already timed
        logic [CNT_W-1:0]   seg;     // clocks since the last edge
        logic [CNT_W-1:0]   unit;    // start-bit length
        logic [PRE_W-1:0]   pre;     // span modulo 9*CLOCK_FACTOR
        logic [CNT_W-1:0]   quo;     // span divided by 9*CLOCK_FACTOR
        logic [GUARD_W-1:0] idle;    // consecutive high clocks while hunting
        logic [GUARD_W-1:0] guard;   // idle clocks needed before arming
        logic               upd;
        logic [CNT_W-1:0]   div;
    } meas_t;

    meas_t r_d, r_q;

    logic [EXT_W-1:0] seg_ext, unit_ext, half, expect_len, lo_lim, hi_lim;
    logic             gap_ok;
    logic             any_edge;

    always_comb begin
        seg_ext  = EXT_W'(r_q.seg);
        unit_ext = EXT_W'(r_q.unit);
        half     = unit_ext >> 1;
        case (r_q.gap_n)
            3'd1, 3'd2: expect_len = unit_ext;
            3'd3:       expect_len = unit_ext << 1;
            default:    expect_len = unit_ext << 2;
        endcase
        lo_lim   = expect_len - half;
        hi_lim   = expect_len + half;
        gap_ok   = (seg_ext >= lo_lim) && (seg_ext <= hi_lim);
        any_edge = fall | rise;
    end

    always_comb begin
        r_d     = r_q;
        r_d.upd = 1'b0;
        unique case (r_q.st)
            MS_HUNT: begin
                if (fall && (r_q.idle >= r_q.guard)) begin
                    r_d.st    = MS_MEAS;
                    r_d.gap_n = 3'd0;
                    r_d.seg   = CNT_W'(1);
                    r_d.pre   = PRE_W'(1);
                    r_d.quo   = '0;
                end else if (!line) begin
                    r_d.idle = '0;
                end else if (r_q.idle != IDLE_MAX) begin
                    r_d.idle = r_q.idle + GUARD_W'(1);
                end
            end
            MS_MEAS: begin
                if (r_q.pre == PRE_LAST) begin
                    r_d.pre = '0;
                    r_d.quo = r_q.quo + CNT_W'(1);
                end else begin
                    r_d.pre = r_q.pre + PRE_W'(1);
                end
                if (any_edge) begin
                    if (r_q.gap_n == 3'd0) begin
                        r_d.unit  = r_q.seg;
                        r_d.seg   = CNT_W'(1);
                        r_d.gap_n = 3'd1;
                    end else if (!gap_ok || (r_q.gap_n == LAST_GAP_IDX)) begin
                        r_d.st    = MS_HUNT;
                        r_d.idle  = '0;
                        r_d.guard = {r_q.unit, 1'b0};
                        if (gap_ok && (r_q.quo != '0)) begin
                            r_d.upd = 1'b1;
                            r_d.div = r_q.quo;
                        end
                    end else begin
                        r_d.seg   = CNT_W'(1);
                        r_d.gap_n = r_q.gap_n + 3'd1;
                    end
                end else if (r_q.seg == SEG_MAX) begin
                    r_d.st    = MS_HUNT;
                    r_d.idle  = '0;
                    r_d.guard = '0;
                end else begin
                    r_d.seg = r_q.seg + CNT_W'(1);
                end
            end
            default: r_d.st = MS_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= MS_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign upd_valid = r_q.upd;
    assign upd_div   = r_q.div;

endmodule

// File: rtl/ab_rate_gen.sv
module ab_rate_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [CNT_W-1:0] upd_div,
    output logic             tick,
    output logic             locked,
    output logic [CNT_W-1:0] cur_div
);

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        logic             lock;
        logic             tick;
    } rate_t;

    rate_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (upd_valid) begin
            r_d.div  = upd_div;
            r_d.cnt  = '0;
            r_d.lock = 1'b1;
            r_d.tick = 1'b0;
        end else if (r_q.cnt == (r_q.div - CNT_W'(1))) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + CNT_W'(1);
            r_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.div  <= '1;   // slowest rate until trained
            r_q.cnt  <= '0;
            r_q.lock <= 1'b0;
            r_q.tick <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick    = r_q.tick;
    assign locked  = r_q.lock;
    assign cur_div = r_q.div;

endmodule

// File: rtl/cr_autobaud.sv
module cr_autobaud #(
    parameter int CLOCK_FACTOR   = 8,
    parameter int LOG2_MAX_COUNT = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic baud_tick,
    output logic locked
);

    logic                      line, fall, rise;
    logic                      upd_valid;
    logic [LOG2_MAX_COUNT-1:0] upd_div;
    logic [LOG2_MAX_COUNT-1:0] cur_div;

    ab_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .rxd  (rxd),
        .line (line),
        .fall (fall),
        .rise (rise)
    );

    ab_measure #(
        .CNT_W       (LOG2_MAX_COUNT),
        .CLOCK_FACTOR(CLOCK_FACTOR)
    ) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .line     (line),
        .fall     (fall),
        .rise     (rise),
        .upd_valid(upd_valid),
        .upd_div  (upd_div)
    );

    ab_rate_gen #(
        .CNT_W(LOG2_MAX_COUNT)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_valid(upd_valid),
        .upd_div  (upd_div),
        .tick     (baud_tick),
        .locked   (locked),
        .cur_div  (cur_div)
    );

endmodule

// File: rtl/cr_autobaud_checker.sv
module cr_autobaud_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_tick,
    input logic             locked,
    input logic             upd_valid,
    input logic [CNT_W-1:0] upd_div,
    input logic [CNT_W-1:0] cur_div
);

    AST_LOCK_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(upd_valid)); // R1

    AST_UNLOCKED_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (cur_div == {CNT_W{1'b1}})); // R2

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R3

    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(cur_div)); // R4

    AST_UPD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_div != '0)); // R5

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && (cur_div > CNT_W'(1))) |=> !baud_tick); // R7

endmodule

bind cr_autobaud cr_autobaud_checker #(
    .CNT_W(LOG2_MAX_COUNT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .baud_tick(baud_tick),
    .locked   (locked),
    .upd_valid(upd_valid),
    .upd_div  (upd_div),
    .cur_div  (cur_div)
);

// File: tb/cr_autobaud_bench.sv
module cr_autobaud_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CF         = 8;
    localparam int CW         = 12;
    localparam int DEF_DIV    = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic baud_tick, locked;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int    exp_per_q[$];
    int    exp_lock_q[$];
    string exp_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_autobaud #(
        .CLOCK_FACTOR  (CF),
        .LOG2_MAX_COUNT(CW),
        .SYNC_STAGES   (2)
    ) u_cr_autobaud (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (rxd),
        .baud_tick(baud_tick),
        .locked   (locked)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cr_div(input int p);
        return (9 * p) / (9 * CF);
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One character, LSB first, one stop bit, then three idle bit times
    task automatic send_char(input logic [7:0] c, input int p);
        rxd = 1'b0;
        hold(p);
        for (int i = 0; i < 8; i++) begin
            rxd = c[i];
            hold(p);
        end
        rxd = 1'b1;
        hold(4 * p);
    endtask

    task automatic expect_rate(input int per, input int lk, input string tag);
        exp_per_q.push_back(per);
        exp_lock_q.push_back(lk);
        exp_tag_q.push_back(tag);
        while (exp_per_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops an expected rate and compares it with the tick spacing
    initial begin
        forever begin
            int per;
            while (exp_per_q.size() == 0) @(negedge clk);
            while (!baud_tick) @(negedge clk);
            per = 0;
            do begin
                @(negedge clk);
                per++;
            end while (!baud_tick);
            check(per == exp_per_q[0], {exp_tag_q[0], " tick spacing"}, per, exp_per_q[0]);
            check(int'(locked) == exp_lock_q[0], {exp_tag_q[0], " locked"}, int'(locked), exp_lock_q[0]);
            void'(exp_per_q.pop_front());
            void'(exp_lock_q.pop_front());
            void'(exp_tag_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        hold(5);
        check(locked == 1'b0, "R2 reset locked", int'(locked), 0);
        check(baud_tick == 1'b0, "R2 reset tick", int'(baud_tick), 0);
        rst_n = 1'b1;
        hold(2);
        // R2: untrained rate
        expect_rate(DEF_DIV, 0, "R2");
        // R1: first carriage return
        send_char(8'h0D, 80);
        expect_rate(cr_div(80), 1, "R1 p80");
        // R3: retrain slower without reset
        send_char(8'h0D, 200);
        expect_rate(cr_div(200), 1, "R3 p200");
        // R1: truncation of a non-integer quotient (765/72)
        send_char(8'h0D, 85);
        expect_rate(cr_div(85), 1, "R1 p85");
        // R4: look-alike characters are ignored
        send_char(8'h55, 120);
        expect_rate(cr_div(85), 1, "R4 0x55");
        send_char(8'h0B, 96);
        expect_rate(cr_div(85), 1, "R4 0x0B");
        // R5: valid pattern but zero quotient
        send_char(8'h0D, 7);
        expect_rate(cr_div(85), 1, "R5 p7");
        // R6: line break saturates the gap counter
        rxd = 1'b0;
        hold(5000);
        rxd = 1'b1;
        hold(100);
        expect_rate(cr_div(85), 1, "R6 break");
        send_char(8'h0D, 40);
        expect_rate(cr_div(40), 1, "R6 recover");
        // R7: divisor one and two
        send_char(8'h0D, 8);
        expect_rate(1, 1, "R7 div1");
        send_char(8'h0D, 16);
        expect_rate(2, 1, "R7 div2");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule